// File: doc/BRIEF.md
# Threshold DAC Serial Configuration Master

This block drives the three-wire configuration link of a 32-channel discriminator board. The board carries four 8-channel discriminator chips, and each chip takes its threshold from one channel of a 4-channel, 10-bit DAC. One DAC step is 4 mV, so a code of N sets a threshold of 4·N mV for all eight channels of that chip. The same link also fires the board's built-in test pulse, which is used for functional checks.

A host presents four threshold codes and raises a one-cycle write request, or raises a one-cycle fire request. The block then becomes busy. It shifts the frames out on a divided serial clock and closes each frame with a load strobe. When the last strobe has been sent, it drops busy and gives a one-cycle done pulse. The board tells the two kinds of frame apart by the number of bits it has clocked in when the strobe arrives: 12 bits for a DAC write and 2 bits for a fire command.

Top module: `thrSerialLoader`

## Requirements
- R1: While reset is held and in the first cycle after it is released, busy, done, sclk and sload are all low.
- R2: An accepted write request sends exactly four frames, one for each DAC channel, in the order 0, 1, 2, 3. Each frame is 12 bits sent MSB first: the 2-bit channel number in bits 11:10, then the 10-bit code in bits 9:0.
- R3: Every frame is followed by sload high for exactly one system-clock cycle. sclk is low during that cycle, and the strobe comes after the falling edge that ends the frame's last bit.
- R4: The serial clock has a period of CLK_DIV system cycles (default 4). In each bit it is low for CLK_DIV/2 cycles, then high for the remaining cycles. sdata changes only in the cycle where sclk falls or while sclk is low, and it is stable across each rising edge of sclk.
- R5: An accepted fire request sends one 2-bit frame carrying the opcode 2'b10 (1 first, then 0), followed by one load strobe. This strobe is the single-cycle test-pulse request at the board.
- R6: busy goes high in the cycle after a request is accepted. It stays high for frames × (bits × CLK_DIV + 1) cycles: 4 × 49 = 196 for a write and 9 for a fire. done pulses for one cycle, with busy low, right after the last strobe.
- R7: Requests that arrive while busy is high are ignored. No extra frame is sent afterwards, and the frames in progress keep the codes captured when the job was accepted.
- R8: If a write request and a fire request arrive in the same idle cycle, the write is performed and the fire request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrAllReq | input | 1 | One-cycle request to write all four thresholds |
| fireReq | input | 1 | One-cycle request to fire the test pulse |
| thrCodes | input | 40 | Four 10-bit codes; channel c is in bits [10c+9:10c] |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job completes |
| sclk | output | 1 | Serial clock to the board |
| sdata | output | 1 | Serial data, sampled by the board on the rising edge of sclk |
| sload | output | 1 | Load strobe that closes a frame |

## Verification
The hardest situations to reach are the two collisions: a request arriving in the middle of a frame, and both requests arriving in the same idle cycle. A request mid-frame can only be produced by timing a pulse deep inside a busy window. The bench starts a write, waits ten cycles so that it is in the first frame, then pulses both requests while changing the codes. It then checks that the frames still carry the original codes and that nothing follows the done pulse. Codes are swept arithmetically and with walking-one patterns. A bench-side receiver rebuilds each frame from the rising edges of sclk and measures clock phase widths. This shows that every address and code bit reaches the right position.

// File: rtl/thrLoaderPkg.sv
package thrLoaderPkg;

  // Strobes from the sequencer to the shift datapath
  typedef struct packed {
    logic captureCodes;  // latch host codes
    logic loadWrite;     // load a DAC write frame for chSel
    logic loadFire;      // load the test-pulse command frame
    logic shiftBit;      // advance to next bit (with falling sclk)
    logic riseClk;       // drive sclk high
    logic fallClk;       // drive sclk low
    logic pulseLoad;     // raise the frame strobe for one cycle
  } strobeT;

  localparam logic [1:0] FIRE_OPCODE = 2'b10;
  localparam int FIRE_BITS = 2;

endpackage

// File: rtl/cfgCtrl.sv
module cfgCtrl
  import thrLoaderPkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int FRAME_W = 12,
  parameter int CLK_DIV = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrAllReq,
  input  logic                      fireReq,
  output logic                      busy,
  output logic                      done,
  output logic [$clog2(NUM_CH)-1:0] chSel,
  output strobeT                    stb
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int DIV_W = $clog2(CLK_DIV);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam int HALF  = CLK_DIV / 2;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_LOAD} stateT;

  stateT            state;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitsLeft;
  logic [CH_W-1:0]  chCnt;
  logic             isFire;

  assign busy  = (state != S_IDLE);
  assign chSel = (state == S_IDLE) ? '0 : chCnt + 1'b1;

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE: begin
        if (wrAllReq) begin            // write wins over fire (R8)
          stb.captureCodes = 1'b1;
          stb.loadWrite    = 1'b1;
        end else if (fireReq) begin
          stb.loadFire = 1'b1;
        end
      end
      S_SHIFT: begin
        if (divCnt == DIV_W'(HALF - 1)) stb.riseClk = 1'b1;
        if (divCnt == DIV_W'(CLK_DIV - 1)) begin
          stb.fallClk = 1'b1;
          if (bitsLeft == '0) stb.pulseLoad = 1'b1;
          else                stb.shiftBit  = 1'b1;
        end
      end
      S_LOAD: begin
        if (!isFire && chCnt != CH_W'(NUM_CH - 1)) stb.loadWrite = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      divCnt   <= '0;
      bitsLeft <= '0;
      chCnt    <= '0;
      isFire   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (stb.loadWrite || stb.loadFire) begin
        state    <= S_SHIFT;
        divCnt   <= '0;
        bitsLeft <= stb.loadFire ? CNT_W'(FIRE_BITS - 1) : CNT_W'(FRAME_W - 1);
        isFire   <= stb.loadFire;
        chCnt    <= chSel;
      end else begin
        case (state)
          S_SHIFT: begin
            divCnt <= (divCnt == DIV_W'(CLK_DIV - 1)) ? '0 : divCnt + 1'b1;
            if (stb.fallClk) begin
              if (bitsLeft == '0) state <= S_LOAD;
              else                bitsLeft <= bitsLeft - 1'b1;
            end
          end
          S_LOAD: begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R6: done only with busy low, and every job end gives done
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_end_flags_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R7: a job only starts from a host request seen while idle
  p_start_on_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wrAllReq || fireReq));
  // R8: simultaneous requests start a write job
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wrAllReq && fireReq) |=> (busy && !isFire));

endmodule

// File: rtl/cfgShift.sv
module cfgShift
  import thrLoaderPkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 10,
  parameter int CLK_DIV = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     stb,
  input  logic [$clog2(NUM_CH)-1:0]  chSel,
  input  logic [NUM_CH*CODE_W-1:0]   thrCodes,
  output logic                       sclk,
  output logic                       sdata,
  output logic                       sload
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int FRAME_W = CH_W + CODE_W;
  localparam int HALF    = CLK_DIV / 2;
  localparam int HI_W    = $clog2(CLK_DIV + 1);

  logic [CODE_W-1:0]  inCode  [NUM_CH];
  logic [CODE_W-1:0]  codeReg [NUM_CH];
  logic [FRAME_W-1:0] shReg;
  logic [CODE_W-1:0]  selCode;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    assign inCode[g] = thrCodes[g*CODE_W +: CODE_W];
    always_ff @(posedge clk) begin
      if (!rstN)                 codeReg[g] <= '0;
      else if (stb.captureCodes) codeReg[g] <= inCode[g];
    end
  end

  // first frame of a job takes the code straight from the host bus
  assign selCode = stb.captureCodes ? inCode[chSel] : codeReg[chSel];
  assign sdata   = shReg[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      sclk  <= 1'b0;
      sload <= 1'b0;
    end else begin
      if (stb.loadWrite)     shReg <= {chSel, selCode};
      else if (stb.loadFire) shReg <= {FIRE_OPCODE, {(FRAME_W-2){1'b0}}};
      else if (stb.shiftBit) shReg <= {shReg[FRAME_W-2:0], 1'b0};
      if (stb.riseClk)      sclk <= 1'b1;
      else if (stb.fallClk) sclk <= 1'b0;
      sload <= stb.pulseLoad;
    end
  end

  // cycles spent high, for the phase-width check
  logic [HI_W-1:0] hiCnt;
  always_ff @(posedge clk) begin
    if (!rstN)     hiCnt <= '0;
    else if (sclk) hiCnt <= hiCnt + 1'b1;
    else           hiCnt <= '0;
  end

  // R4: data held across each rising edge, high phase of fixed width
  p_data_setup_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdata));
  p_high_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (hiCnt == HI_W'(CLK_DIV - HALF)));
  // R3: strobe with clock low, exactly one cycle long
  p_strobe_clk_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    sload |-> !sclk);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    sload |=> !sload);

endmodule

// File: rtl/thrSerialLoader.sv
module thrSerialLoader
  import thrLoaderPkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CODE_W  = 10,
  parameter int CLK_DIV = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrAllReq,
  input  logic                     fireReq,
  input  logic [NUM_CH*CODE_W-1:0] thrCodes,
  output logic                     busy,
  output logic                     done,
  output logic                     sclk,
  output logic                     sdata,
  output logic                     sload
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int FRAME_W = CH_W + CODE_W;

  strobeT          stb;
  logic [CH_W-1:0] chSel;

  cfgCtrl #(.NUM_CH(NUM_CH), .FRAME_W(FRAME_W), .CLK_DIV(CLK_DIV)) uCtrl (
    .clk(clk), .rstN(rstN), .wrAllReq(wrAllReq), .fireReq(fireReq),
    .busy(busy), .done(done), .chSel(chSel), .stb(stb)
  );

  cfgShift #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .CLK_DIV(CLK_DIV)) uShift (
    .clk(clk), .rstN(rstN), .stb(stb), .chSel(chSel), .thrCodes(thrCodes),
    .sclk(sclk), .sdata(sdata), .sload(sload)
  );

endmodule

// File: tb/tb_thrSerialLoader.sv
module tb_thrSerialLoader;
  localparam int NUM_CH  = 4;
  localparam int CODE_W  = 10;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;
  localparam int WR_BUSY = NUM_CH * (12 * CLK_DIV + 1);
  localparam int FI_BUSY = 2 * CLK_DIV + 1;

  logic clk = 1'b0, rstN = 1'b0, wrAllReq = 1'b0, fireReq = 1'b0;
  logic [NUM_CH*CODE_W-1:0] thrCodes = '0;
  logic busy, done, sclk, sdata, sload;

  thrSerialLoader dut (.clk(clk), .rstN(rstN), .wrAllReq(wrAllReq), .fireReq(fireReq),
    .thrCodes(thrCodes), .busy(busy), .done(done), .sclk(sclk), .sdata(sdata), .sload(sload));

  always #2 clk = ~clk;

  int nChecks = 0, nFails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // board-side receiver model
  logic [15:0] acc = '0;
  int nBits = 0, nFr = 0, doneCnt = 0, busyCyc = 0, timErr = 0, hiRun = 0, loRun = 0;
  logic [15:0] frm [16];
  int frmLen [16];
  logic prevSclk = 1'b0, prevSdata = 1'b0;

  always @(posedge sclk) begin
    acc = {acc[14:0], sdata};
    nBits++;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (sload) begin
        if (nFr < 16) begin frm[nFr] = acc; frmLen[nFr] = nBits; end
        nFr++; nBits = 0; acc = '0;
        if (sclk) timErr++;
      end
      if (done) begin doneCnt++; if (busy) timErr++; end
      if (busy) busyCyc++;
      if (sclk && prevSclk && sdata !== prevSdata) timErr++;
      if (sclk && !prevSclk) begin
        if (sdata !== prevSdata) timErr++;
        if (nBits >= 2 && loRun != HALF) timErr++;
      end
      if (!sclk && prevSclk && hiRun != CLK_DIV - HALF) timErr++;
      hiRun = sclk ? hiRun + 1 : 0;
      loRun = sclk ? 0 : loRun + 1;
      prevSclk = sclk; prevSdata = sdata;
    end
  end

  task automatic clearMon();
    nFr = 0; doneCnt = 0; busyCyc = 0; timErr = 0;
  endtask

  task automatic startJob(input bit wr, input bit fi, input logic [NUM_CH*CODE_W-1:0] codes);
    @(negedge clk);
    thrCodes = codes; wrAllReq = wr; fireReq = fi;
    @(negedge clk);
    wrAllReq = 1'b0; fireReq = 1'b0;
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busy && t < 2000) begin @(negedge clk); t++; end
    check(t < 2000, "R6 job completes", t, 2000);
    @(negedge clk);
  endtask

  task automatic checkWriteFrames(input logic [NUM_CH*CODE_W-1:0] codes, input string tag);
    check(nFr == NUM_CH, {tag, " R2 frame count"}, nFr, NUM_CH);
    for (int c = 0; c < NUM_CH; c++) begin
      logic [11:0] expF;
      expF = {2'(c), codes[c*CODE_W +: CODE_W]};
      check(frm[c][11:0] == expF, {tag, " R2 frame content"}, int'(frm[c][11:0]), int'(expF));
      check(frmLen[c] == 12, {tag, " R2 frame length"}, frmLen[c], 12);
    end
    check(doneCnt == 1, {tag, " R6 done pulses"}, doneCnt, 1);
    check(busyCyc == WR_BUSY, {tag, " R6 busy cycles"}, busyCyc, WR_BUSY);
    check(timErr == 0, {tag, " R3/R4 timing errors"}, timErr, 0);
  endtask

  task automatic doWrite(input logic [NUM_CH*CODE_W-1:0] codes, input string tag);
    clearMon();
    startJob(1'b1, 1'b0, codes);
    check(busy == 1'b1, {tag, " R6 busy after accept"}, int'(busy), 1);
    waitIdle();
    checkWriteFrames(codes, tag);
  endtask

  function automatic logic [NUM_CH*CODE_W-1:0] mixCodes(input int k);
    logic [NUM_CH*CODE_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++)
      v[c*CODE_W +: CODE_W] = CODE_W'((k * 97 + c * 331 + k * k * 13) % 1024);
    return v;
  endfunction

  function automatic logic [NUM_CH*CODE_W-1:0] walkCodes(input int b);
    logic [NUM_CH*CODE_W-1:0] v;
    for (int c = 0; c < NUM_CH; c++)
      v[c*CODE_W +: CODE_W] = CODE_W'(1) << ((b + c) % CODE_W);
    return v;
  endfunction

  initial begin
    logic [NUM_CH*CODE_W-1:0] codesA, codesB;
    repeat (3) @(negedge clk);
    check({busy, done, sclk, sload} == 4'b0, "R1 outputs during reset", int'({busy, done, sclk, sload}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, sclk, sload} == 4'b0, "R1 outputs after reset", int'({busy, done, sclk, sload}), 0);

    // R2 R3 R4 R6: code sweeps
    doWrite('0, "zeros");
    doWrite({NUM_CH*CODE_W{1'b1}}, "ones");
    for (int b = 0; b < CODE_W; b++) doWrite(walkCodes(b), "walk");
    for (int k = 0; k < 24; k++) doWrite(mixCodes(k), "mix");

    // R5: fire command frame
    clearMon();
    startJob(1'b0, 1'b1, mixCodes(5));
    waitIdle();
    check(nFr == 1, "R5 fire frame count", nFr, 1);
    check(frmLen[0] == 2, "R5 fire frame length", frmLen[0], 2);
    check(frm[0][1:0] == 2'b10, "R5 fire opcode", int'(frm[0][1:0]), 2);
    check(doneCnt == 1, "R5 fire done pulse", doneCnt, 1);
    check(busyCyc == FI_BUSY, "R6 fire busy cycles", busyCyc, FI_BUSY);
    check(timErr == 0, "R3 fire strobe timing", timErr, 0);

    // R7: requests during busy are ignored, captured codes kept
    codesA = mixCodes(31); codesB = mixCodes(47);
    clearMon();
    startJob(1'b1, 1'b0, codesA);
    repeat (10) @(negedge clk);
    thrCodes = codesB; wrAllReq = 1'b1; fireReq = 1'b1;
    @(negedge clk);
    wrAllReq = 1'b0; fireReq = 1'b0;
    repeat (60) @(negedge clk);
    thrCodes = codesA ^ codesB; wrAllReq = 1'b1;
    @(negedge clk);
    wrAllReq = 1'b0;
    waitIdle();
    checkWriteFrames(codesA, "R7 ignore");
    repeat (80) @(negedge clk);
    check(nFr == NUM_CH, "R7 no frame after done", nFr, NUM_CH);
    check(busy == 1'b0, "R7 idle after ignored requests", int'(busy), 0);

    // R8: write wins over a simultaneous fire
    codesA = mixCodes(53);
    clearMon();
    startJob(1'b1, 1'b1, codesA);
    waitIdle();
    repeat (20) @(negedge clk);
    checkWriteFrames(codesA, "R8 collide");
    check(nFr == NUM_CH, "R8 no fire frame", nFr, NUM_CH);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule